// File: doc/BRIEF.md
# Three-Wide Decode Steering with Fused Memory Micro-ops

This block steers already-classified instructions onto a decode stage that is three decoders wide. Lane 0 is a complex decoder that can emit up to four micro-ops. The other lanes are simple decoders, and each emits one queue entry per cycle. Each cycle the fetch side presents a window of up to three instructions, oldest in lane 0. Each instruction carries its plain micro-op count and a flag that marks the fusible memory forms: a store, or a load combined with an operation. When fusion is on, a fusible instruction whose plain count is two becomes one fused micro-op. A fused micro-op fills one queue entry but still stands for two constituent micro-ops, so a simple decoder can take it. This keeps long runs of memory instructions off the complex decoder.

The block answers in the same cycle with how many of the presented instructions it accepted, so the fetch side can advance its window. The group is built strictly in program order. It stops at the first instruction that cannot be placed, and the cap is the free space that the micro-op queue reports. An instruction longer than four micro-ops raises a request to the microcode engine, and steering stalls until that engine reports completion. A fusion-off control makes fusible forms behave as ordinary two-micro-op instructions, so that decode throughput with and without fusion can be compared. The counts for what was placed appear one cycle later.

Top module: `dec_steer_fuse`

## Requirements
- R1: `take_cnt` is combinational in the same cycle. It counts accepted instructions starting from lane 0, and it stops at the first lane whose `in_valid` bit is low, so a valid lane after an invalid one is never taken.
- R2: An instruction that is not fused and has a count of 2 to 4 is accepted only in lane 0, where it uses the complex decoder. In lane 1 or lane 2, such an instruction ends the group before itself.
- R3: With `fuse_off` low, an instruction that has `in_fusible` set and a count of exactly 2 is accepted in any lane. It writes one queue entry and counts as two micro-ops in `out_uops` and as one in `out_fused`. In every cycle, `out_uops` equals `out_entries` plus `out_fused`.
- R4: With `fuse_off` high, the `in_fusible` flag has no effect. Such an instruction follows R2, and `out_fused` is 0 in the following cycle.
- R5: The queue entries of one cycle never exceed `q_free`. The group is cut at the first instruction whose entries would not fit, and this includes lane 0.
- R6: An instruction with a count above 4 is accepted only in lane 0, with `take_cnt`=1, and it writes no queue entries. From the next cycle `ucode_req` is high and `take_cnt` is 0. This holds up to and including the cycle in which `ucode_done` is high. `ucode_req` falls in the cycle after that.
- R7: `out_entries`, `out_uops`, `out_fused` and `out_simple_used` are registered and describe the group accepted in the previous cycle. `out_simple_used` is the number of accepted lanes other than lane 0.
- R8: After reset, every count output is 0 and `ucode_req` is low.
- R9: Back-to-back windows of three fusible two-micro-op instructions, with fusion on and enough free space, give three entries and six micro-ops in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 3 | Valid bit per lane; bit 0 is the oldest instruction |
| in_nuops | input | 9 | Plain micro-op count per lane, 3 bits each; lane i at bits [3i+2:3i] |
| in_fusible | input | 3 | Per-lane flag marking a fusible memory form |
| fuse_off | input | 1 | High: fusion is disabled |
| q_free | input | 4 | Free entries in the micro-op queue |
| ucode_done | input | 1 | Microcode engine has finished the long instruction |
| take_cnt | output | 2 | Number of instructions accepted this cycle |
| ucode_req | output | 1 | A long instruction is held at the microcode engine |
| out_entries | output | 3 | Queue entries written by the previous group |
| out_uops | output | 4 | Constituent micro-ops of the previous group |
| out_fused | output | 2 | Fused micro-ops in the previous group |
| out_simple_used | output | 2 | Simple decoders used by the previous group |

## Verification
The properties assume that every valid lane carries a count of at least 1, and that `ucode_done` is raised only while `ucode_req` is high. The bench keeps to both assumptions: its table holds only counts from 1 to 4, so no vector from the table starts a microcode hold. The microcode handshake is driven only from the directed sequence, which raises `ucode_done` only after `ucode_req` has been observed high.

// File: rtl/dec_steer_pkg.sv
package dec_steer_pkg;

  parameter int unsigned NUOP_W = 3;

  typedef struct packed {
    logic              fused;
    logic              cplx;
    logic              ucode;
    logic [NUOP_W-1:0] ent;
    logic [NUOP_W-1:0] uops;
  } lane_cls_t;

  // Classify one instruction for steering.
  function automatic lane_cls_t classify(input logic [NUOP_W-1:0] n,
                                         input logic fusible,
                                         input logic fuse_off,
                                         input int unsigned cplx_max);
    lane_cls_t c;
    c.fused = fusible && !fuse_off && (n == NUOP_W'(2));
    c.ucode = (32'(n) > cplx_max);
    c.cplx  = !c.fused && !c.ucode && (n > NUOP_W'(1));
    c.ent   = c.ucode ? '0 : (c.fused ? NUOP_W'(1) : n);
    c.uops  = c.ucode ? '0 : n;
    return c;
  endfunction

  // Room check against queue free space.
  function automatic logic room_ok(input int unsigned used,
                                   input int unsigned add,
                                   input int unsigned free);
    return (used + add) <= free;
  endfunction

endpackage

// File: rtl/dec_lane_class.sv
module dec_lane_class
  import dec_steer_pkg::*;
#(
  parameter int unsigned CPLX_MAX = 4
) (
  input  logic [NUOP_W-1:0] nuops,
  input  logic              fusible,
  input  logic              fuse_off,
  output lane_cls_t         cls
);
  assign cls = classify(nuops, fusible, fuse_off, CPLX_MAX);
endmodule

// File: rtl/dec_group_sel.sv
module dec_group_sel
  import dec_steer_pkg::*;
#(
  parameter int unsigned LANES = 3,
  parameter int unsigned QW    = 4,
  parameter int unsigned TW    = 2,
  parameter int unsigned EW    = 3,
  parameter int unsigned UW    = 4
) (
  input  logic [LANES-1:0] valid,
  input  lane_cls_t        cls [LANES],
  input  logic             busy,
  input  logic [QW-1:0]    q_free,
  output logic [TW-1:0]    take,
  output logic [EW-1:0]    ent_sum,
  output logic [UW-1:0]    uop_sum,
  output logic [TW-1:0]    fus_sum,
  output logic [LANES-1:0] acc_mask,
  output logic             ucode_go
);
  always_comb begin : walk
    logic stop;
    stop     = busy;
    take     = '0;
    ent_sum  = '0;
    uop_sum  = '0;
    fus_sum  = '0;
    acc_mask = '0;
    ucode_go = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (!stop) begin
        if (!valid[i]) begin
          stop = 1'b1;
        end else if (i == 0 && cls[i].ucode) begin
          take     = TW'(1);
          ucode_go = 1'b1;
          acc_mask[i] = 1'b1;
          stop     = 1'b1;
        end else if (i != 0 && (cls[i].cplx || cls[i].ucode)) begin
          stop = 1'b1;
        end else if (!room_ok(32'(ent_sum), 32'(cls[i].ent), 32'(q_free))) begin
          stop = 1'b1;
        end else begin
          ent_sum     = ent_sum + EW'(cls[i].ent);
          uop_sum     = uop_sum + UW'(cls[i].uops);
          fus_sum     = fus_sum + TW'(cls[i].fused);
          take        = take + TW'(1);
          acc_mask[i] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dec_ucode_ctl.sv
module dec_ucode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic done,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            busy <= 1'b0;
    else if (busy && done) busy <= 1'b0;
    else if (go)           busy <= 1'b1;
  end
endmodule

// File: rtl/dec_steer_fuse.sv
module dec_steer_fuse
  import dec_steer_pkg::*;
#(
  parameter int unsigned LANES    = 3,
  parameter int unsigned CPLX_MAX = 4,
  parameter int unsigned QW       = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [LANES-1:0]                       in_valid,
  input  logic [LANES*NUOP_W-1:0]                in_nuops,
  input  logic [LANES-1:0]                       in_fusible,
  input  logic                                   fuse_off,
  input  logic [QW-1:0]                          q_free,
  input  logic                                   ucode_done,
  output logic [$clog2(LANES+1)-1:0]             take_cnt,
  output logic                                   ucode_req,
  output logic [$clog2(CPLX_MAX+LANES)-1:0]      out_entries,
  output logic [$clog2(CPLX_MAX+2*LANES-1)-1:0]  out_uops,
  output logic [$clog2(LANES+1)-1:0]             out_fused,
  output logic [$clog2(LANES)-1:0]               out_simple_used
);
  localparam int unsigned TW = $clog2(LANES+1);
  localparam int unsigned EW = $clog2(CPLX_MAX+LANES);
  localparam int unsigned UW = $clog2(CPLX_MAX+2*LANES-1);
  localparam int unsigned SW = $clog2(LANES);

  lane_cls_t        cls [LANES];
  logic [TW-1:0]    grp_take;
  logic [EW-1:0]    grp_ent;
  logic [UW-1:0]    grp_uops;
  logic [TW-1:0]    grp_fus;
  logic [LANES-1:0] grp_mask;
  logic             ucode_go;
  logic             busy;
  logic [TW-1:0]    simple_nxt;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dec_lane_class #(.CPLX_MAX(CPLX_MAX)) u_cls (
      .nuops   (in_nuops[g*NUOP_W +: NUOP_W]),
      .fusible (in_fusible[g]),
      .fuse_off(fuse_off),
      .cls     (cls[g])
    );
  end

  dec_group_sel #(.LANES(LANES), .QW(QW), .TW(TW), .EW(EW), .UW(UW)) u_grp (
    .valid   (in_valid),
    .cls     (cls),
    .busy    (busy),
    .q_free  (q_free),
    .take    (grp_take),
    .ent_sum (grp_ent),
    .uop_sum (grp_uops),
    .fus_sum (grp_fus),
    .acc_mask(grp_mask),
    .ucode_go(ucode_go)
  );

  dec_ucode_ctl u_uc (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (ucode_go),
    .done (ucode_done),
    .busy (busy)
  );

  // Lanes beyond lane 0 go to simple decoders.
  assign simple_nxt = (grp_mask[0] && !ucode_go) ? (grp_take - TW'(1)) : '0;

  assign take_cnt  = grp_take;
  assign ucode_req = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_entries     <= '0;
      out_uops        <= '0;
      out_fused       <= '0;
      out_simple_used <= '0;
    end else begin
      out_entries     <= grp_ent;
      out_uops        <= grp_uops;
      out_fused       <= grp_fus;
      out_simple_used <= simple_nxt[SW-1:0];
    end
  end
endmodule

// File: rtl/dec_steer_fuse_chk.sv
module dec_steer_fuse_chk
  import dec_steer_pkg::*;
#(
  parameter int unsigned LANES    = 3,
  parameter int unsigned CPLX_MAX = 4,
  parameter int unsigned QW       = 4
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic [LANES-1:0]                      in_valid,
  input logic [LANES*NUOP_W-1:0]               in_nuops,
  input logic                                  fuse_off,
  input logic [QW-1:0]                         q_free,
  input logic                                  ucode_done,
  input logic [$clog2(LANES+1)-1:0]            take_cnt,
  input logic                                  ucode_req,
  input logic [$clog2(CPLX_MAX+LANES)-1:0]     out_entries,
  input logic [$clog2(CPLX_MAX+2*LANES-1)-1:0] out_uops,
  input logic [$clog2(LANES+1)-1:0]            out_fused,
  input logic [$clog2(LANES)-1:0]              out_simple_used
);
  p_prefix_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take_cnt != 0) |-> in_valid[0]);

  p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid[0] |=> (out_entries == 0 && out_simple_used == 0));

  p_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(out_uops) == 32'(out_entries) + 32'(out_fused));

  p_nofuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_off |=> (out_fused == 0));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_cnt != 0) |=> (32'(out_entries) <= 32'($past(q_free))));

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_req |-> (take_cnt == 0));

  p_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ucode_req && in_valid[0] && 32'(in_nuops[NUOP_W-1:0]) > CPLX_MAX) |=> ucode_req);

  p_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ucode_req && ucode_done) |=> !ucode_req);
endmodule

bind dec_steer_fuse dec_steer_fuse_chk #(.LANES(LANES), .CPLX_MAX(CPLX_MAX), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_nuops(in_nuops),
  .fuse_off(fuse_off), .q_free(q_free), .ucode_done(ucode_done),
  .take_cnt(take_cnt), .ucode_req(ucode_req), .out_entries(out_entries),
  .out_uops(out_uops), .out_fused(out_fused), .out_simple_used(out_simple_used)
);

// File: tb/dec_steer_fuse_tb.sv
module dec_steer_fuse_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] in_valid = '0;
  logic [8:0] in_nuops = '0;
  logic [2:0] in_fusible = '0;
  logic       fuse_off = 1'b0;
  logic [3:0] q_free = 4'd15;
  logic       ucode_done = 1'b0;
  logic [1:0] take_cnt;
  logic       ucode_req;
  logic [2:0] out_entries;
  logic [3:0] out_uops;
  logic [1:0] out_fused;
  logic [1:0] out_simple_used;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dec_steer_fuse u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_nuops(in_nuops),
    .in_fusible(in_fusible), .fuse_off(fuse_off), .q_free(q_free),
    .ucode_done(ucode_done), .take_cnt(take_cnt), .ucode_req(ucode_req),
    .out_entries(out_entries), .out_uops(out_uops), .out_fused(out_fused),
    .out_simple_used(out_simple_used)
  );

  typedef struct packed {
    logic [2:0] v;
    logic [2:0] n0, n1, n2;
    logic [2:0] fus;
    logic       foff;
    logic [3:0] q;
    logic [1:0] e_take;
    logic [2:0] e_ent;
    logic [3:0] e_uop;
    logic [1:0] e_fus;
    logic [1:0] e_sim;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'b111, 3'd1, 3'd1, 3'd1, 3'b000, 1'b0, 4'd15, 2'd3, 3'd3, 4'd3, 2'd0, 2'd2}, // R1 plain singles
    '{3'b111, 3'd2, 3'd1, 3'd1, 3'b000, 1'b0, 4'd15, 2'd3, 3'd4, 4'd4, 2'd0, 2'd2}, // R2 complex first
    '{3'b111, 3'd1, 3'd2, 3'd1, 3'b000, 1'b0, 4'd15, 2'd1, 3'd1, 4'd1, 2'd0, 2'd0}, // R2 group cut
    '{3'b111, 3'd2, 3'd2, 3'd2, 3'b111, 1'b0, 4'd15, 2'd3, 3'd3, 4'd6, 2'd3, 2'd2}, // R3 all fused
    '{3'b111, 3'd2, 3'd2, 3'd2, 3'b111, 1'b1, 4'd15, 2'd1, 3'd2, 4'd2, 2'd0, 2'd0}, // R4 fusion off
    '{3'b111, 3'd4, 3'd1, 3'd2, 3'b100, 1'b0, 4'd15, 2'd3, 3'd6, 4'd7, 2'd1, 2'd2}, // R3 mixed peak
    '{3'b111, 3'd1, 3'd1, 3'd1, 3'b000, 1'b0, 4'd2,  2'd2, 3'd2, 4'd2, 2'd0, 2'd1}, // R5 queue cap
    '{3'b111, 3'd3, 3'd1, 3'd1, 3'b000, 1'b0, 4'd2,  2'd0, 3'd0, 4'd0, 2'd0, 2'd0}, // R5 lane0 no room
    '{3'b101, 3'd1, 3'd1, 3'd1, 3'b000, 1'b0, 4'd15, 2'd1, 3'd1, 4'd1, 2'd0, 2'd0}, // R1 hole
    '{3'b000, 3'd1, 3'd1, 3'd1, 3'b000, 1'b0, 4'd15, 2'd0, 3'd0, 4'd0, 2'd0, 2'd0}, // R1 empty
    '{3'b111, 3'd2, 3'd3, 3'd1, 3'b001, 1'b0, 4'd15, 2'd1, 3'd1, 4'd2, 2'd1, 2'd0}, // R2 fused then complex
    '{3'b111, 3'd1, 3'd1, 3'd1, 3'b000, 1'b0, 4'd0,  2'd0, 3'd0, 4'd0, 2'd0, 2'd0}, // R5 full queue
    '{3'b111, 3'd1, 3'd2, 3'd2, 3'b010, 1'b0, 4'd15, 2'd2, 3'd2, 4'd3, 2'd1, 2'd1}  // R3 unfused tail cut
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] v, input logic [2:0] a, input logic [2:0] b,
                       input logic [2:0] c, input logic [2:0] f, input logic fo,
                       input logic [3:0] q);
    in_valid   = v;
    in_nuops   = {c, b, a};
    in_fusible = f;
    fuse_off   = fo;
    q_free     = q;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R8", "out_entries", int'(out_entries), 0);
    chk("R8", "out_uops", int'(out_uops), 0);
    chk("R8", "out_simple_used", int'(out_simple_used), 0);
    chk("R8", "ucode_req", int'(ucode_req), 0);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      vec_t t;
      t = VECS[i];
      @(negedge clk);
      drive(t.v, t.n0, t.n1, t.n2, t.fus, t.foff, t.q);
      #1;
      chk("R1", $sformatf("vec%0d take_cnt", i), int'(take_cnt), int'(t.e_take));
      @(negedge clk);
      chk("R7", $sformatf("vec%0d out_entries", i), int'(out_entries), int'(t.e_ent));
      chk("R3", $sformatf("vec%0d out_uops", i), int'(out_uops), int'(t.e_uop));
      chk("R4", $sformatf("vec%0d out_fused", i), int'(out_fused), int'(t.e_fus));
      chk("R7", $sformatf("vec%0d out_simple_used", i), int'(out_simple_used), int'(t.e_sim));
      drive(3'b000, 3'd1, 3'd1, 3'd1, 3'b000, 1'b0, 4'd15);
    end

    // R9: sustained fused peak
    @(negedge clk);
    drive(3'b111, 3'd2, 3'd2, 3'd2, 3'b111, 1'b0, 4'd15);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9", "sustained out_uops", int'(out_uops), 6);
      chk("R9", "sustained out_entries", int'(out_entries), 3);
    end

    // R6: microcode hold
    drive(3'b001, 3'd5, 3'd1, 3'd1, 3'b000, 1'b0, 4'd15);
    #1;
    chk("R6", "long take_cnt", int'(take_cnt), 1);
    @(negedge clk);
    chk("R6", "ucode_req raised", int'(ucode_req), 1);
    chk("R6", "long out_entries", int'(out_entries), 0);
    drive(3'b111, 3'd1, 3'd1, 3'd1, 3'b000, 1'b0, 4'd15);
    #1;
    chk("R6", "stall take_cnt", int'(take_cnt), 0);
    @(negedge clk);
    chk("R6", "still busy", int'(ucode_req), 1);
    chk("R6", "stall out_entries", int'(out_entries), 0);
    ucode_done = 1'b1;
    #1;
    chk("R6", "done-cycle take_cnt", int'(take_cnt), 0);
    @(negedge clk);
    ucode_done = 1'b0;
    chk("R6", "ucode_req released", int'(ucode_req), 0);
    #1;
    chk("R6", "resume take_cnt", int'(take_cnt), 3);
    @(negedge clk);
    chk("R6", "resume out_entries", int'(out_entries), 3);
    drive(3'b000, 3'd1, 3'd1, 3'd1, 3'b000, 1'b0, 4'd15);

    // R8: reset again clears counts
    @(negedge clk);
    drive(3'b111, 3'd4, 3'd1, 3'd1, 3'b000, 1'b0, 4'd15);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8", "reset out_entries", int'(out_entries), 0);
    chk("R8", "reset out_uops", int'(out_uops), 0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule